// File: doc/BRIEF.md
# Predicated Vector Load/Store Sequencer

This block runs one non-widening transfer between a 128-bit vector register and memory. The element size is 8, 16 or 32 bits. The caller presents the decoded instruction fields, the base register value, a 16-bit lane predicate, the beat-progress code and the current contents of the target vector register, then pulses `start`. The block splits the register into elements and issues one memory access per active element on a valid/ready port. At the end it returns the merged register value, the updated base and any rejection flags.

The byte offset is the 7-bit immediate scaled by the element size, and it is subtracted when the add bit is clear. Pre-indexed forms begin at base plus offset. Post-indexed forms begin at the base itself. The address steps by one element for every element, including those the predicate disables, which issue no access. When writeback is requested, the new base is reported once with `done`, whatever the predicate. Encodings that cannot execute are rejected before any memory traffic.

Top module: `vec_ldst_seq`

## Requirements
- R1: The byte offset is `imm` shifted left by `esize_code` (0 = byte, 1 = halfword, 2 = word). It is two's-complement negated when `add_off` is 0.
- R2: Element i is addressed at S + i*E, where E = 1 << `esize_code` bytes and S is the first address. S is `base_val` + offset when `pre_idx` = 1, and `base_val` otherwise. The address advances for every element, masked or not.
- R3: Element i is active exactly when `lane_mask[i*E]` is 1, and only active elements raise `mem_req_valid`. Each request carries `mem_size` = `esize_code` and `mem_we` = not `is_load`.
- R4: For a load, the bytes of an active element i in `vec_out` (bytes i*E to i*E+E-1, little-endian) take the low E bytes of `mem_rdata` from that element's handshake. Bytes of inactive elements keep their value from `vec_in`.
- R5: For a store, `mem_wdata` holds element i of `vec_in` in its low E bytes, with all higher bits zero.
- R6: On an accepted transfer with `wback` = 1, `wb_en` is high together with `done`. At that point `wb_idx` = `base_idx` and `wb_val` = `base_val` + offset, for both indexing forms and for any mask, including all-zero. `wb_en` is 0 when `wback` is 0 or the transfer is rejected.
- R7: `undef` is raised with `done` when any of these holds: `base_idx` = 15; `base_idx` = 13 with `wback`; `vreg_idx` >= 8; `esize_code` = 3; or `pre_idx` = 0 with `wback` = 0. A rejected transfer makes no memory request and leaves `vec_out` equal to `vec_in`.
- R8: A beat-progress code `eci` of 3, 6 or 7 raises `inv_state` instead of executing, with no request and no writeback. Other codes execute normally. `undef` takes precedence, and the two flags are never raised together.
- R9: A request held without `mem_req_ready` keeps `mem_req_valid` high and `mem_addr` unchanged. Exactly one element transfers per handshake.
- R10: `busy` is high from the cycle after an accepted `start` until `done`, which lasts one cycle. A `start` seen while `busy` is ignored. A rejected transfer completes with `done` one cycle after `start`.
- R11: After reset, `busy`, `done` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer when idle |
| base_idx | input | 4 | Index of the base register |
| imm | input | 7 | Unscaled offset magnitude |
| add_off | input | 1 | 1 adds the offset, 0 subtracts it |
| pre_idx | input | 1 | 1 applies the offset before the first access |
| wback | input | 1 | Report an updated base |
| is_load | input | 1 | 1 load, 0 store |
| esize_code | input | 2 | Element size code |
| vreg_idx | input | 4 | Vector register index |
| eci | input | 3 | Beat-progress code |
| base_val | input | 32 | Base register value |
| lane_mask | input | 16 | Byte-lane predicate |
| vec_in | input | 128 | Current vector register contents |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Undefined-encoding flag, valid with done |
| inv_state | output | 1 | Invalid-state flag, valid with done |
| wb_en | output | 1 | Base writeback request, valid with done |
| wb_idx | output | 4 | Register receiving the writeback |
| wb_val | output | 32 | Updated base value |
| vec_out | output | 128 | Resulting vector register value |
| mem_req_valid | output | 1 | Element access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Byte address of the element |
| mem_size | output | 2 | Access size code |
| mem_we | output | 1 | 1 for a write |
| mem_wdata | output | 32 | Store element in the low bytes |
| mem_rdata | input | 32 | Load data, valid in the handshake cycle |

## Verification
The assertions check the port protocol on every cycle. A stalled request holds its address. The address moves by exactly one element per step. `done` never lasts two cycles. An idle or rejected sequencer issues no request, and a rejected transfer never asks for writeback. Only the bench scenarios can show the arithmetic: the scaled and signed offsets, the start address under both indexing forms, which elements the predicate selects at each size, the merged load result, the zero-extended store data and the decode of every rejected encoding. They also show that a second `start` during a transfer changes nothing.

// File: rtl/vls_pkg.sv
package vls_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_FIN  = 2'd2
   } seq_state_t;

   localparam logic [1:0] SIZE_RSVD = 2'd3;

   function automatic logic eci_is_reserved(input logic [2:0] code);
      return (code == 3'd3) || (code == 3'd6) || (code == 3'd7);
   endfunction

endpackage

// File: rtl/vls_decode.sv
module vls_decode
   import vls_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int IMM_W     = 7,
   parameter int RIDX_W    = 4,
   parameter int VIDX_W    = 4,
   parameter int NUM_VREGS = 8
) (
   input  logic [RIDX_W-1:0] base_idx,
   input  logic [IMM_W-1:0]  imm,
   input  logic              add_off,
   input  logic              pre_idx,
   input  logic              wback,
   input  logic [1:0]        esize_code,
   input  logic [VIDX_W-1:0] vreg_idx,
   input  logic [2:0]        eci,
   input  logic [ADDR_W-1:0] base_val,
   output logic              rej_undef,
   output logic              rej_state,
   output logic [ADDR_W-1:0] first_addr,
   output logic [ADDR_W-1:0] new_base
);
   localparam logic [RIDX_W-1:0] IDX_PC = RIDX_W'(15);
   localparam logic [RIDX_W-1:0] IDX_SP = RIDX_W'(13);

   if (RIDX_W < 4) begin : g_ridx_chk
      $error("vls_decode: RIDX_W must be at least 4");
   end
   if (ADDR_W <= IMM_W + 2) begin : g_addr_chk
      $error("vls_decode: ADDR_W too small for the scaled offset");
   end

   logic [ADDR_W-1:0] mag;
   logic [ADDR_W-1:0] offs;
   logic              bad_base, bad_vreg, bad_size, other_enc;

   assign mag   = ADDR_W'(imm) << esize_code;
   assign offs  = add_off ? mag : (~mag + ADDR_W'(1));

   assign bad_base  = (base_idx == IDX_PC) || ((base_idx == IDX_SP) && wback);
   assign bad_vreg  = {1'b0, vreg_idx} >= (VIDX_W + 1)'(NUM_VREGS);
   assign bad_size  = (esize_code == SIZE_RSVD);
   assign other_enc = !pre_idx && !wback;

   assign rej_undef  = bad_base || bad_vreg || bad_size || other_enc;
   assign rej_state  = !rej_undef && eci_is_reserved(eci);
   assign new_base   = base_val + offs;
   assign first_addr = pre_idx ? new_base : base_val;

endmodule

// File: rtl/vls_lane.sv
module vls_lane #(
   parameter int VEC_BYTES = 16,
   parameter int DATA_W    = 32
) (
   input  logic [VEC_BYTES*8-1:0]       vec_q,
   input  logic [$clog2(VEC_BYTES)-1:0] bptr,
   input  logic [1:0]                   esize_code,
   input  logic                         wr_en,
   input  logic [DATA_W-1:0]            rdata,
   output logic [VEC_BYTES*8-1:0]       vec_d,
   output logic [DATA_W-1:0]            wdata
);
   localparam int BW  = $clog2(VEC_BYTES);
   localparam int DB  = DATA_W / 8;
   localparam int DBW = $clog2(DB);

   if (DATA_W < 32 || (DATA_W % 8) != 0 || (DB & (DB - 1)) != 0) begin : g_dw_chk
      $error("vls_lane: DATA_W must be a power-of-two byte count of at least 4 bytes");
   end
   if (VEC_BYTES < DB) begin : g_vb_chk
      $error("vls_lane: VEC_BYTES must hold at least one data word");
   end

   logic [DBW-1:0] emask;
   assign emask = DBW'((32'd1 << esize_code) - 32'd1);

   // register byte merge: one slice per vector byte
   for (genvar b = 0; b < VEC_BYTES; b++) begin : g_vbyte
      logic           in_elem;
      logic [DBW-1:0] boff;
      assign in_elem = (BW'(b) >> esize_code) == (bptr >> esize_code);
      assign boff    = DBW'(b) & emask;
      assign vec_d[b*8 +: 8] = (wr_en && in_elem) ? rdata[{boff, 3'b000} +: 8]
                                                  : vec_q[b*8 +: 8];
   end

   // store data: element bytes in the low lanes, zero above
   for (genvar j = 0; j < DB; j++) begin : g_wbyte
      logic [BW-1:0] src;
      assign src = bptr + BW'(j);
      assign wdata[j*8 +: 8] = (32'(j) < (32'd1 << esize_code)) ? vec_q[{src, 3'b000} +: 8]
                                                                : 8'h00;
   end

endmodule

// File: rtl/vec_ldst_seq.sv
module vec_ldst_seq
   import vls_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int VEC_BYTES = 16,
   parameter int IMM_W     = 7,
   parameter int RIDX_W    = 4,
   parameter int VIDX_W    = 4,
   parameter int NUM_VREGS = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [RIDX_W-1:0]      base_idx,
   input  logic [IMM_W-1:0]       imm,
   input  logic                   add_off,
   input  logic                   pre_idx,
   input  logic                   wback,
   input  logic                   is_load,
   input  logic [1:0]             esize_code,
   input  logic [VIDX_W-1:0]      vreg_idx,
   input  logic [2:0]             eci,
   input  logic [ADDR_W-1:0]      base_val,
   input  logic [VEC_BYTES-1:0]   lane_mask,
   input  logic [VEC_BYTES*8-1:0] vec_in,
   output logic                   busy,
   output logic                   done,
   output logic                   undef,
   output logic                   inv_state,
   output logic                   wb_en,
   output logic [RIDX_W-1:0]      wb_idx,
   output logic [ADDR_W-1:0]      wb_val,
   output logic [VEC_BYTES*8-1:0] vec_out,
   output logic                   mem_req_valid,
   input  logic                   mem_req_ready,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [1:0]             mem_size,
   output logic                   mem_we,
   output logic [DATA_W-1:0]      mem_wdata,
   input  logic [DATA_W-1:0]      mem_rdata
);
   localparam int BW    = $clog2(VEC_BYTES);
   localparam int VEC_W = VEC_BYTES * 8;

   if (VEC_BYTES < 4 || (VEC_BYTES & (VEC_BYTES - 1)) != 0) begin : g_vb_chk
      $error("vec_ldst_seq: VEC_BYTES must be a power of two, at least 4");
   end

   // ---------------- decode at start ----------------
   logic              dec_undef, dec_state;
   logic [ADDR_W-1:0] dec_first, dec_base;

   vls_decode #(
      .ADDR_W(ADDR_W), .IMM_W(IMM_W), .RIDX_W(RIDX_W),
      .VIDX_W(VIDX_W), .NUM_VREGS(NUM_VREGS)
   ) u_dec (
      .base_idx(base_idx), .imm(imm), .add_off(add_off), .pre_idx(pre_idx),
      .wback(wback), .esize_code(esize_code), .vreg_idx(vreg_idx), .eci(eci),
      .base_val(base_val), .rej_undef(dec_undef), .rej_state(dec_state),
      .first_addr(dec_first), .new_base(dec_base)
   );

   // ---------------- sequencer state ----------------
   seq_state_t         state;
   logic [BW-1:0]      bptr;
   logic [ADDR_W-1:0]  addr_q;
   logic [1:0]         size_q;
   logic               load_q, wb_q, undef_q, state_q;
   logic [VEC_BYTES-1:0] mask_q;
   logic [VEC_W-1:0]   vreg_q;
   logic [ADDR_W-1:0]  nbase_q;
   logic [RIDX_W-1:0]  bidx_q;

   logic              accept, active, step, hs, last;
   logic [BW:0]       esz, bptr_nxt;
   logic [VEC_W-1:0]  vreg_d;

   assign accept   = start && (state == SQ_IDLE);
   assign active   = mask_q[bptr];
   assign esz      = (BW + 1)'(1) << size_q;
   assign bptr_nxt = {1'b0, bptr} + esz;
   assign last     = (bptr_nxt >= (BW + 1)'(VEC_BYTES));
   assign step     = (state == SQ_RUN) && (!active || mem_req_ready);
   assign hs       = mem_req_valid && mem_req_ready;

   vls_lane #(.VEC_BYTES(VEC_BYTES), .DATA_W(DATA_W)) u_lane (
      .vec_q(vreg_q), .bptr(bptr), .esize_code(size_q), .wr_en(hs && load_q),
      .rdata(mem_rdata), .vec_d(vreg_d), .wdata(mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         bptr    <= '0;
         addr_q  <= '0;
         size_q  <= '0;
         load_q  <= 1'b0;
         wb_q    <= 1'b0;
         undef_q <= 1'b0;
         state_q <= 1'b0;
         mask_q  <= '0;
         vreg_q  <= '0;
         nbase_q <= '0;
         bidx_q  <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: if (accept) begin
               bptr    <= '0;
               addr_q  <= dec_first;
               size_q  <= esize_code;
               load_q  <= is_load;
               wb_q    <= wback;
               undef_q <= dec_undef;
               state_q <= dec_state;
               mask_q  <= lane_mask;
               vreg_q  <= vec_in;
               nbase_q <= dec_base;
               bidx_q  <= base_idx;
               state   <= (dec_undef || dec_state) ? SQ_FIN : SQ_RUN;
            end
            SQ_RUN: if (step) begin
               vreg_q <= vreg_d;
               bptr   <= bptr_nxt[BW-1:0];
               addr_q <= addr_q + ADDR_W'(esz);
               if (last) state <= SQ_FIN;
            end
            SQ_FIN:  state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   // ---------------- outputs ----------------
   assign busy          = (state != SQ_IDLE);
   assign done          = (state == SQ_FIN);
   assign undef         = done && undef_q;
   assign inv_state     = done && state_q;
   assign wb_en         = done && wb_q && !undef_q && !state_q;
   assign wb_idx        = bidx_q;
   assign wb_val        = nbase_q;
   assign vec_out       = vreg_q;
   assign mem_req_valid = (state == SQ_RUN) && active;
   assign mem_addr      = addr_q;
   assign mem_size      = size_q;
   assign mem_we        = !load_q;

   // ---------------- assertions ----------------
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr))) else $error("request dropped or moved while stalled"); // R9
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !last) |=> (mem_addr == $past(mem_addr) + ADDR_W'($past(esz)))) else $error("address did not advance by one element"); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid) else $error("request while idle"); // R11
   AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (undef_q || state_q)) |-> !mem_req_valid) else $error("rejected transfer touched memory"); // R7
   AST_REJECT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (undef || inv_state) |-> !wb_en) else $error("writeback on rejected transfer"); // R6
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(undef && inv_state)) else $error("both rejection flags raised"); // R8

endmodule

// File: tb/sim_vec_ldst_seq.sv
`timescale 1ns/1ps
module sim_vec_ldst_seq;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [3:0]   base_idx = '0;
   logic [6:0]   imm = '0;
   logic         add_off = 1'b0, pre_idx = 1'b0, wback = 1'b0, is_load = 1'b0;
   logic [1:0]   esize_code = '0;
   logic [3:0]   vreg_idx = '0;
   logic [2:0]   eci = '0;
   logic [31:0]  base_val = '0;
   logic [15:0]  lane_mask = '0;
   logic [127:0] vec_in = '0;
   logic         busy, done, undef, inv_state, wb_en;
   logic [3:0]   wb_idx;
   logic [31:0]  wb_val;
   logic [127:0] vec_out;
   logic         mem_req_valid, mem_we;
   logic         mem_req_ready = 1'b0;
   logic [31:0]  mem_addr, mem_wdata, mem_rdata;
   logic [1:0]   mem_size;

   always #4 clk = ~clk;

   vec_ldst_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .base_idx(base_idx), .imm(imm),
      .add_off(add_off), .pre_idx(pre_idx), .wback(wback), .is_load(is_load),
      .esize_code(esize_code), .vreg_idx(vreg_idx), .eci(eci), .base_val(base_val),
      .lane_mask(lane_mask), .vec_in(vec_in), .busy(busy), .done(done),
      .undef(undef), .inv_state(inv_state), .wb_en(wb_en), .wb_idx(wb_idx),
      .wb_val(wb_val), .vec_out(vec_out), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // behavioural memory: byte at address a is a fixed function of a
   function automatic logic [7:0] pat(input logic [31:0] a);
      logic [31:0] t;
      t = a * 32'd37 + (a >> 3) + 32'd5;
      return t[7:0];
   endfunction

   assign mem_rdata = {pat(mem_addr + 32'd3), pat(mem_addr + 32'd2),
                       pat(mem_addr + 32'd1), pat(mem_addr)};

   always @(negedge clk) mem_req_ready <= (($urandom % 3) != 0);

   // handshake and done monitor
   logic [31:0] log_addr [0:63];
   logic [1:0]  log_sz   [0:63];
   logic        log_we   [0:63];
   logic [31:0] log_wd   [0:63];
   int          hs_total = 0;
   int          done_total = 0;

   always @(posedge clk) begin
      if (rst_n && mem_req_valid && mem_req_ready) begin
         log_addr[hs_total & 63] <= mem_addr;
         log_sz[hs_total & 63]   <= mem_size;
         log_we[hs_total & 63]   <= mem_we;
         log_wd[hs_total & 63]   <= mem_wdata;
         hs_total = hs_total + 1;
      end
      if (rst_n && done) done_total = done_total + 1;
   end

   int  n_chk = 0;
   int  n_err = 0;
   bit  finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] bi, input logic [6:0] im, input bit ad,
                         input bit pr, input bit wb, input bit ld, input logic [1:0] sz,
                         input logic [3:0] vi, input logic [2:0] ec, input logic [31:0] bv,
                         input logic [15:0] mk, input logic [127:0] vin, input bit inject);
      int          esz, nel, k, cyc, log_base, done_base;
      logic [31:0] off, first, nb, w;
      logic [127:0] exp_vec;
      bit          e_undef, e_inv, busy_ok, addr_ok, attr_ok, wd_ok;
      e_undef = (bi == 4'd15) || (bi == 4'd13 && wb) || (vi >= 4'd8) || (sz == 2'd3) || (!pr && !wb);
      e_inv   = !e_undef && (ec == 3'd3 || ec == 3'd6 || ec == 3'd7);
      esz = 1 << sz;
      off = {25'd0, im} << sz;
      if (!ad) off = -off;
      nb    = bv + off;
      first = pr ? nb : bv;

      @(negedge clk);
      base_idx = bi; imm = im; add_off = ad; pre_idx = pr; wback = wb; is_load = ld;
      esize_code = sz; vreg_idx = vi; eci = ec; base_val = bv; lane_mask = mk; vec_in = vin;
      log_base = hs_total; done_base = done_total;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0; busy_ok = 1'b1;
      while (!done && cyc < 2000) begin
         if (!busy) busy_ok = 1'b0;
         if (inject && cyc == 1) begin
            start = 1'b1; base_idx = 4'd15; vreg_idx = 4'd9;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      chk(cyc < 2000, "R10", "done reached", 128'(cyc), 128'(0));
      chk(busy_ok && busy, "R10", "busy until done", 128'(busy), 128'(1));
      chk(undef == e_undef, "R7", "undef flag", 128'(undef), 128'(e_undef));
      chk(inv_state == e_inv, "R8", "inv_state flag", 128'(inv_state), 128'(e_inv));
      if (e_undef || e_inv) begin
         chk(cyc == 0, "R10", "reject latency", 128'(cyc), 128'(0));
         chk(hs_total == log_base, "R7", "no access on reject", 128'(hs_total - log_base), 128'(0));
         chk(!wb_en, "R6", "no writeback on reject", 128'(wb_en), 128'(0));
         chk(vec_out == vin, "R7", "register untouched", vec_out, vin);
      end else begin
         nel = 16 / esz; k = 0;
         addr_ok = 1'b1; attr_ok = 1'b1; wd_ok = 1'b1;
         exp_vec = vin;
         for (int i = 0; i < nel; i++) begin
            if (mk[i * esz]) begin
               if (log_addr[(log_base + k) & 63] != first + 32'(i * esz)) addr_ok = 1'b0;
               if (log_sz[(log_base + k) & 63] != sz || log_we[(log_base + k) & 63] != !ld) attr_ok = 1'b0;
               w = '0;
               for (int j = 0; j < esz; j++) begin
                  w[j*8 +: 8] = vin[(i * esz + j) * 8 +: 8];
                  exp_vec[(i * esz + j) * 8 +: 8] = pat(first + 32'(i * esz + j));
               end
               if (!ld && log_wd[(log_base + k) & 63] != w) wd_ok = 1'b0;
               k++;
            end
         end
         chk(hs_total - log_base == k, "R3", "active element count", 128'(hs_total - log_base), 128'(k));
         chk(addr_ok, "R2", "element address sequence", 128'(log_addr[log_base & 63]), 128'(first));
         chk(attr_ok, "R3", "request size and direction", 128'(log_sz[log_base & 63]), 128'(sz));
         if (ld) chk(vec_out == exp_vec, "R4", "merged load result", vec_out, exp_vec);
         else    chk(wd_ok && vec_out == vin, "R5", "store data zero-extended", 128'(log_wd[log_base & 63]), 128'(0));
         chk(wb_en == wb, "R6", "writeback enable", 128'(wb_en), 128'(wb));
         if (wb) begin
            chk(wb_val == nb, "R1", "updated base value", 128'(wb_val), 128'(nb));
            chk(wb_idx == bi, "R6", "writeback index", 128'(wb_idx), 128'(bi));
         end
      end
      @(negedge clk);
      chk(!done && !busy, "R10", "done single pulse", 128'({done, busy}), 128'(0));
      if (inject) begin
         repeat (3) @(negedge clk);
         chk(done_total == done_base + 1 && !busy, "R10", "start ignored while busy",
             128'(done_total - done_base), 128'(1));
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_req_valid, "R11", "reset state",
          128'({busy, done, mem_req_valid}), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // sweep: size x add x indexing form x direction x mask pattern
      for (int sz = 0; sz < 3; sz++)
         for (int ad = 0; ad < 2; ad++)
            for (int form = 0; form < 3; form++)
               for (int ld = 0; ld < 2; ld++)
                  for (int mp = 0; mp < 4; mp++) begin
                     logic [15:0] mk;
                     bit pr, wb;
                     pr = (form != 0);
                     wb = (form != 1);
                     mk = (mp == 0) ? 16'hFFFF : (mp == 1) ? 16'h0000 : 16'($urandom);
                     run_op(4'($urandom % 13), 7'($urandom), ad[0], pr, wb, ld[0], 2'(sz), 4'($urandom % 8),
                            3'(mp == 3 ? 5 : 0), 32'h200 + 32'($urandom % 64), mk,
                            {$urandom, $urandom, $urandom, $urandom}, 1'b0);
                  end

      // R1 extremes of the immediate
      run_op(4'd2, 7'h7F, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 4'd1, 3'd0, 32'h300, 16'hFFFF, {4{32'hA5A5_5A5A}}, 1'b0);
      run_op(4'd2, 7'h7F, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 4'd7, 3'd0, 32'h100, 16'h5A5A, {4{32'h1234_5678}}, 1'b0);
      run_op(4'd2, 7'h00, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 4'd0, 3'd4, 32'h250, 16'h8001, {4{32'hDEAD_BEEF}}, 1'b0);

      // R7 rejected encodings, and the legal neighbour with base 13
      run_op(4'd15, 7'd4, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 4'd1, 3'd0, 32'h200, 16'hFFFF, {4{32'h1111_2222}}, 1'b0);
      run_op(4'd13, 7'd4, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 4'd1, 3'd0, 32'h200, 16'hFFFF, {4{32'h3333_4444}}, 1'b0);
      run_op(4'd13, 7'd4, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 4'd1, 3'd0, 32'h200, 16'hFFFF, {4{32'h3333_4444}}, 1'b0);
      run_op(4'd3, 7'd4, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 4'd8, 3'd0, 32'h200, 16'hFFFF, {4{32'h5555_6666}}, 1'b0);
      run_op(4'd3, 7'd4, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 4'd2, 3'd0, 32'h200, 16'hFFFF, {4{32'h7777_8888}}, 1'b0);
      run_op(4'd3, 7'd4, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 4'd2, 3'd0, 32'h200, 16'hFFFF, {4{32'h9999_AAAA}}, 1'b0);

      // R8 beat-progress codes, and precedence of undef
      for (int ec = 0; ec < 8; ec++)
         run_op(4'd4, 7'd3, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 4'd3, 3'(ec), 32'h220, 16'hF0F0,
                {$urandom, $urandom, $urandom, $urandom}, 1'b0);
      run_op(4'd15, 7'd3, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 4'd3, 3'd6, 32'h220, 16'hFFFF, {4{32'h0}}, 1'b0);

      // R10 second start during a transfer
      run_op(4'd5, 7'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 4'd2, 3'd0, 32'h240, 16'hFFFF,
             {$urandom, $urandom, $urandom, $urandom}, 1'b1);

      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule